// File: doc/BRIEF.md
# Receive Word Boundary Aligner

This block sits behind a deserializer whose parallel words start at an arbitrary bit of the serial stream. It chooses a bit offset and, on every cycle, outputs a word that starts at that offset. Bit 0 of each input word is the earliest received bit. The selected slice is taken from a window made of the previous parallel word and the current one.

There are two modes. In manual mode a request starts a search for a programmable pattern. The block locks the offset to the first match and holds it until the next request. In slip mode each request moves the boundary by one bit. The pattern can be shorter than the parameter maximum: only its low bits, up to the selected length, are compared. For a 20-bit word this allows lengths of 7, 10 or 20 bits.

A build option makes the block run one search by itself when reset is released, so that a wide link aligns without help. Later searches still need a request.

Top module: `wa_word_aligner`

## Requirements
- R1: While reset is low, the aligned word, the detect flag and the sync flag are all 0. The offset is 0 after reset.
- R2: In manual mode the offset changes only during a search. Once locked, a pattern that appears at another offset leaves the offset and the sync flag unchanged until the next request.
- R3: A search compares the pattern at every offset 0..W-1 of the window {current word, previous word}, with bit 0 of the previous word at window bit 0. The lowest matching offset is chosen. A search with no match stays pending and is retried on each new word.
- R4: Only the low `pat_len_i` pattern bits are compared, with pattern bit 0 matched against the earliest window bit. Pattern bits above the length are ignored. Lengths 7, 10 and 20 are supported with W=20.
- R5: With AUTO_ALIGN=1, a search is pending from reset release without any request.
- R6: In slip mode (`mode_i`=1) each request edge advances the offset by one. After offset W-1 it wraps to 0. The new offset applies from the word after the edge.
- R7: A request acts on its rising edge only. A request held high causes exactly one search or one slip.
- R8: The detect flag is 1 for the aligned word produced when a search locks. When no search is active, it is 1 whenever the aligned word starts with the pattern at the current offset. Otherwise it is 0.
- R9: The sync flag goes to 1 on lock. A request clears it unless that same word locks. It stays 0 in slip mode.
- R10: After the clock edge that takes input word n, the output holds window bits [off +: W] of {word n, word n-1}, where off is the locked offset. This is a latency of one word plus one register, for any offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 1 | 0 = manual pattern alignment, 1 = bit slip |
| req_i | input | 1 | Alignment or slip request, acted on at its rising edge |
| pattern_i | input | PMAX | Alignment pattern, bit 0 received first |
| pat_len_i | input | clog2(PMAX+1) | Number of pattern bits compared |
| din_i | input | W | Unaligned parallel word from the deserializer |
| dout_o | output | W | Aligned parallel word |
| pdet_o | output | 1 | Pattern found at the aligned boundary |
| sync_o | output | 1 | Boundary locked by a manual search |

## Verification
The bench places the pattern at offsets other than the locked one. A design that re-searches without a request would move the boundary there. It also puts two patterns in one window: a priority encoder that is the wrong way round would lock to the higher offset. With the 7-bit and 20-bit lengths, it sets junk in the upper pattern bits and feeds a partial 20-bit pattern. A bad length mask then matches the wrong thing or fails to lock. In slip mode the bench runs more than W slips and holds the request high. An aligner that does not wrap, or that slips on every cycle, then produces visibly shifted data.

// File: rtl/wa_pkg.sv
// Package: shared types and sizing helpers for the word aligner.
// Assumes: word width and maximum pattern length are at least 1.
package wa_pkg;

    typedef enum logic {
        WA_MODE_MANUAL = 1'b0,
        WA_MODE_SLIP   = 1'b1
    } wa_mode_e;

    // Number of parallel words the search window must hold so that every
    // offset 0..w-1 can see a full pattern and a full output word.
    function automatic int wa_window_words(input int w, input int pmax);
        int need;
        int words;
        need  = (w - 1 + pmax + w - 1) / w;
        words = (need < 2) ? 2 : need;
        return words;
    endfunction

endpackage

// File: rtl/wa_req_edge.sv
// Module: rising-edge detector for the alignment / slip request.
// Assumes: req_i is synchronous to clk.
module wa_req_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic rise_o,
    output logic req_q_o
);

    logic req_q;

    // Remember last cycle's request level.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req_i;
    end

    assign rise_o  = req_i & ~req_q;
    assign req_q_o = req_q;

endmodule

// File: rtl/wa_pattern_search.sv
// Module: compares the masked pattern at every offset of the window and
// reports the lowest hit plus whether the current offset hits.
// Assumes: WIN >= W - 1 + PMAX; pat_len_i in 1..PMAX.
module wa_pattern_search #(
    parameter int W    = 20,
    parameter int PMAX = 20,
    parameter int WIN  = 40,
    parameter int LW   = 5,
    parameter int OW   = 5
) (
    input  logic [WIN-1:0]  win_i,
    input  logic [PMAX-1:0] pattern_i,
    input  logic [LW-1:0]   pat_len_i,
    input  logic [OW-1:0]   cur_off_i,
    output logic            hit_any_o,
    output logic [OW-1:0]   hit_off_o,
    output logic            hit_cur_o
);

    logic [PMAX-1:0] care;
    logic [W-1:0]    match;

    // Bits below the selected length take part in the compare.
    for (genvar b = 0; b < PMAX; b++) begin : g_care
        assign care[b] = (32'(pat_len_i) > b);
    end

    // One masked comparator per candidate offset.
    for (genvar o = 0; o < W; o++) begin : g_cmp
        assign match[o] = ~|((win_i[o +: PMAX] ^ pattern_i) & care);
    end

    // Lowest matching offset has priority.
    always_comb begin
        hit_off_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (match[i]) hit_off_o = OW'(i);
        end
    end

    assign hit_any_o = |match;
    assign hit_cur_o = (32'(cur_off_i) < W) ? match[cur_off_i] : 1'b0;

endmodule

// File: rtl/wa_boundary_ctl.sv
// Module: owns the boundary offset, the pending-search flag and sync.
// Manual mode locks on a search hit; slip mode steps the offset.
// Assumes: hit inputs are valid in the same cycle as rise_i.
module wa_boundary_ctl #(
    parameter int W          = 20,
    parameter int OW         = 5,
    parameter bit AUTO_ALIGN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slip_mode_i,
    input  logic          rise_i,
    input  logic          hit_any_i,
    input  logic [OW-1:0] hit_off_i,
    output logic [OW-1:0] off_o,
    output logic [OW-1:0] sel_off_o,
    output logic          active_o,
    output logic          lock_o,
    output logic          sync_o,
    output logic          searching_o
);

    localparam logic [OW-1:0] LAST_OFF = OW'(W - 1);

    logic [OW-1:0] off_q;
    logic          search_q;
    logic          sync_q;

    // A search runs when one is pending or a new request arrives.
    always_comb begin
        active_o  = ~slip_mode_i & (search_q | rise_i);
        lock_o    = active_o & hit_any_i;
        sel_off_o = lock_o ? hit_off_i : off_q;
    end

    // Offset, pending search and sync state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q    <= '0;
            search_q <= AUTO_ALIGN;
            sync_q   <= 1'b0;
        end else if (slip_mode_i) begin
            search_q <= 1'b0;
            sync_q   <= 1'b0;
            if (rise_i) off_q <= (off_q == LAST_OFF) ? '0 : off_q + 1'b1;
        end else if (active_o) begin
            if (hit_any_i) begin
                off_q    <= hit_off_i;
                search_q <= 1'b0;
                sync_q   <= 1'b1;
            end else begin
                search_q <= 1'b1;
                sync_q   <= 1'b0;
            end
        end
    end

    assign off_o       = off_q;
    assign sync_o      = sync_q;
    assign searching_o = search_q;

endmodule

// File: rtl/wa_word_aligner.sv
// Module: top of the receive word aligner. Keeps word history, builds the
// search window, and registers the aligned word and detect flag.
// Assumes: din_i bit 0 is the earliest received bit of each word.
module wa_word_aligner #(
    parameter int W          = 20,
    parameter int PMAX       = 20,
    parameter bit AUTO_ALIGN = 1'b1,
    localparam int LW        = $clog2(PMAX + 1),
    localparam int OW        = (W > 1) ? $clog2(W) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_i,
    input  logic            req_i,
    input  logic [PMAX-1:0] pattern_i,
    input  logic [LW-1:0]   pat_len_i,
    input  logic [W-1:0]    din_i,
    output logic [W-1:0]    dout_o,
    output logic            pdet_o,
    output logic            sync_o
);

    import wa_pkg::*;

    localparam int NWIN = wa_window_words(W, PMAX);
    localparam int WIN  = NWIN * W;

    logic [W-1:0]   hist_q [NWIN-1];
    logic [WIN-1:0] win;
    logic           slip_mode;
    logic           rise;
    logic           req_q;
    logic           hit_any;
    logic [OW-1:0]  hit_off;
    logic           hit_cur;
    logic [OW-1:0]  off_q;
    logic [OW-1:0]  sel_off;
    logic           active;
    logic           lock;
    logic           searching;

    assign slip_mode = (wa_mode_e'(mode_i) == WA_MODE_SLIP);

    // Window: oldest word in the low bits, current input on top.
    assign win[(NWIN-1)*W +: W] = din_i;
    for (genvar i = 0; i < NWIN - 1; i++) begin : g_hist
        logic [W-1:0] nxt;
        if (i == NWIN - 2) begin : g_top
            assign nxt = din_i;
        end else begin : g_mid
            assign nxt = hist_q[i+1];
        end
        assign win[i*W +: W] = hist_q[i];

        // Shift one word of history per cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) hist_q[i] <= '0;
            else        hist_q[i] <= nxt;
        end
    end

    wa_req_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_i),
        .rise_o  (rise),
        .req_q_o (req_q)
    );

    wa_pattern_search #(
        .W(W), .PMAX(PMAX), .WIN(WIN), .LW(LW), .OW(OW)
    ) u_search (
        .win_i     (win),
        .pattern_i (pattern_i),
        .pat_len_i (pat_len_i),
        .cur_off_i (off_q),
        .hit_any_o (hit_any),
        .hit_off_o (hit_off),
        .hit_cur_o (hit_cur)
    );

    wa_boundary_ctl #(
        .W(W), .OW(OW), .AUTO_ALIGN(AUTO_ALIGN)
    ) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .slip_mode_i (slip_mode),
        .rise_i      (rise),
        .hit_any_i   (hit_any),
        .hit_off_i   (hit_off),
        .off_o       (off_q),
        .sel_off_o   (sel_off),
        .active_o    (active),
        .lock_o      (lock),
        .sync_o      (sync_o),
        .searching_o (searching)
    );

    // Register the aligned slice and the detect flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_o <= '0;
            pdet_o <= 1'b0;
        end else begin
            dout_o <= win[sel_off +: W];
            pdet_o <= lock | (~active & hit_cur);
        end
    end

endmodule

// File: rtl/wa_word_aligner_chk.sv
// Module: property checker bound into the word aligner top.
// Assumes: connected to the top's internal control signals by bind.
module wa_word_aligner_chk #(
    parameter int W  = 20,
    parameter int OW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          slip_mode,
    input logic          req,
    input logic          req_q,
    input logic          rise,
    input logic          active,
    input logic          hit_any,
    input logic [OW-1:0] off_q,
    input logic [W-1:0]  dout,
    input logic          pdet,
    input logic          sync
);

    assert_slip_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (slip_mode && rise) |=>
        (off_q == (($past(off_q) == OW'(W - 1)) ? '0 : $past(off_q) + 1'b1)));

    assert_hold_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!slip_mode && !active) |=> $stable(off_q));

    assert_held_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (slip_mode && req && req_q) |=> $stable(off_q));

    assert_slip_nosync_R9: assert property (@(posedge clk) disable iff (!rst_n)
        slip_mode |=> !sync);

    assert_req_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!slip_mode && rise && !hit_any) |=> !sync);

    assert_lock_detect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync) |-> pdet);

    assert_known_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({dout, pdet, sync}));

endmodule

bind wa_word_aligner wa_word_aligner_chk #(.W(W), .OW(OW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .slip_mode (slip_mode),
    .req       (req_i),
    .req_q     (req_q),
    .rise      (rise),
    .active    (active),
    .hit_any   (hit_any),
    .off_q     (off_q),
    .dout      (dout_o),
    .pdet      (pdet_o),
    .sync      (sync_o)
);

// File: tb/tb_wa_word_aligner.sv
// Scoreboard bench: the driver computes expected outputs from the
// requirements, the monitor compares after each clock edge.
module tb_wa_word_aligner;

    localparam int W    = 20;
    localparam int PMAX = 20;
    localparam int LW   = $clog2(PMAX + 1);
    localparam logic [9:0]  COMMA = 10'h17C;
    localparam logic [19:0] PAT20 = 20'hA0D7C;

    typedef struct {
        logic [W-1:0] d;
        logic         pd;
        logic         sy;
        string        tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            mode = 1'b0;
    logic            req = 1'b0;
    logic [PMAX-1:0] pattern = {10'h155, COMMA};
    logic [LW-1:0]   pat_len = LW'(10);
    logic [W-1:0]    din = '0;
    logic [W-1:0]    dout;
    logic            pdet;
    logic            sync;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sb[$];
    bit   sq[$];
    bit   alt_bit = 1'b0;
    bit   use_rand = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    // model state
    logic [W-1:0] m_prev = '0;
    int           m_off = 0;
    bit           m_search = 1'b1;
    bit           m_sync = 1'b0;
    bit           m_reqq = 1'b0;

    always #2 clk = ~clk;

    wa_word_aligner dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .req_i(req),
        .pattern_i(pattern), .pat_len_i(pat_len), .din_i(din),
        .dout_o(dout), .pdet_o(pdet), .sync_o(sync)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit match_at(input logic [2*W-1:0] w, input int o);
        for (int i = 0; i < int'(pat_len); i++)
            if (w[o + i] !== pattern[i]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic fill_alt(input int n);
        for (int i = 0; i < n; i++) begin
            sq.push_back(alt_bit);
            alt_bit = ~alt_bit;
        end
    endtask

    task automatic fill_rand(input int n);
        for (int i = 0; i < n; i++) begin
            sq.push_back(lfsr[0]);
            lfsr = (lfsr >> 1) ^ (lfsr[0] ? 16'hB400 : 16'h0000);
        end
    endtask

    task automatic put_pat(input logic [19:0] p, input int len);
        for (int i = 0; i < len; i++) sq.push_back(p[i]);
    endtask

    // Pad with filler so the next pattern starts at this word offset.
    task automatic place(input int off, input logic [19:0] p, input int len);
        fill_alt((off - (sq.size() % W) + W) % W);
        put_pat(p, len);
    endtask

    // Drive one word at a falling edge and queue its expected result.
    task automatic send(input logic r, input string tag);
        logic [W-1:0]   word;
        logic [2*W-1:0] win;
        bit             rise;
        exp_t           e;
        if (sq.size() < W) begin
            if (use_rand) fill_rand(W - sq.size());
            else          fill_alt(W - sq.size());
        end
        for (int i = 0; i < W; i++) word[i] = sq.pop_front();
        din = word;
        req = r;
        win  = {word, m_prev};
        rise = r & ~m_reqq;
        e.tag = tag;
        if (mode) begin
            e.d  = win[m_off +: W];
            e.pd = match_at(win, m_off);
            e.sy = 1'b0;
            m_search = 1'b0;
            m_sync   = 1'b0;
            if (rise) m_off = (m_off == W - 1) ? 0 : m_off + 1;
        end else if (m_search || rise) begin
            int hit;
            hit = -1;
            for (int o = W - 1; o >= 0; o--) if (match_at(win, o)) hit = o;
            if (hit >= 0) begin
                m_off = hit;
                e.d = win[m_off +: W];
                e.pd = 1'b1; e.sy = 1'b1;
                m_search = 1'b0; m_sync = 1'b1;
            end else begin
                e.d = win[m_off +: W];
                e.pd = 1'b0; e.sy = 1'b0;
                m_search = 1'b1; m_sync = 1'b0;
            end
        end else begin
            e.d  = win[m_off +: W];
            e.pd = match_at(win, m_off);
            e.sy = m_sync;
        end
        m_prev = word;
        m_reqq = r;
        sb.push_back(e);
        @(negedge clk);
    endtask

    task automatic sends(input int n, input logic r, input string tag);
        for (int i = 0; i < n; i++) send(r, tag);
    endtask

    // Monitor: compare one queued item just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check({"R10 data ", e.tag}, dout, e.d);
                check({"R8 detect ", e.tag}, W'(pdet), W'(e.pd));
                check({"R9 sync ", e.tag}, W'(sync), W'(e.sy));
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            check("R1 reset dout", dout, '0);
            check("R1 reset pdet", W'(pdet), '0);
            check("R1 reset sync", W'(sync), '0);
        end
        rst_n = 1'b1;
        // R5: automatic search after reset, pattern at offset 7
        place(7, 20'(COMMA), 10);
        sends(5, 1'b0, "R5 auto align");
        // R2: foreign pattern at offset 13 ignored, R8 at locked offset 7
        place(13, 20'(COMMA), 10);
        sends(3, 1'b0, "R2 hold boundary");
        place(7, 20'(COMMA), 10);
        sends(3, 1'b0, "R8 detect at lock");
        // R3/R9: new request, two patterns in one window, lowest wins
        send(1'b1, "R9 request clears");
        sends(2, 1'b0, "R3 pending search");
        place(4, 20'(COMMA), 10);
        fill_alt(1);
        put_pat(20'(COMMA), 10);
        sends(4, 1'b0, "R3 lowest offset");
        // R7: request held high, one search only
        sends(2, 1'b1, "R7 held request");
        place(5, 20'(COMMA), 10);
        sends(3, 1'b1, "R7 held request lock");
        place(11, 20'(COMMA), 10);
        sends(3, 1'b1, "R7 no second search");
        sends(2, 1'b0, "R7 release");
        // R4: 7-bit length with junk above, then 20-bit length
        pat_len = LW'(7);
        pattern = 20'hFFF7C;
        send(1'b1, "R4 len7 request");
        place(9, 20'h0007C, 7);
        sends(4, 1'b0, "R4 len7 lock");
        pat_len = LW'(20);
        pattern = PAT20;
        send(1'b1, "R4 len20 request");
        send(1'b0, "R4 len20 pending");
        place(2, 20'(COMMA), 10);
        sends(2, 1'b0, "R4 partial no lock");
        place(17, PAT20, 20);
        sends(4, 1'b0, "R4 len20 lock");
        // R6: slip mode, more than W slips to exercise the wrap
        mode = 1'b1;
        use_rand = 1'b1;
        pat_len = LW'(10);
        pattern = {10'h155, COMMA};
        for (int k = 0; k < W + 3; k++) begin
            send(1'b1, "R6 slip step");
            send(1'b0, "R6 slip gap");
        end
        sends(6, 1'b1, "R7 held slip");
        sends(3, 1'b0, "R6 after slips");
        // R2/R9: back to manual, lock at offset 0
        mode = 1'b0;
        use_rand = 1'b0;
        send(1'b1, "R9 manual request");
        place(0, 20'(COMMA), 10);
        sends(4, 1'b0, "R3 lock offset zero");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule